// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This unit collects the interrupt requests pending at an instruction boundary and picks one to service. The candidates are a non-maskable line, a level-sensitive maskable request that brings its own type number, and internal requests raised by the core: divide error, software interrupt with a type, breakpoint, overflow and the single-step trap. The winner becomes an 8-bit type number. The unit turns that number into two word addresses in the vector table at the bottom of memory.

It then reads the two words over a simple synchronous memory port. The new instruction offset is read first and the new code segment second. Each read is held until the memory signals ready. When both words are in, the unit shows the offset, the segment and the type, and raises a one-cycle completion pulse. Accepting any request clears the unit's interrupt-enable and single-step flags, so a further maskable request stays blocked until software sets the enable flag again. The core can write both flags through a write strobe.

Top module: `ivec_fetch`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_rd_o`, `if_o` and `tf_o` are 0, and `vec_ip_o`, `vec_cs_o` and `vec_type_o` are 0.
- R2: When several requests are present in the idle state, the priority from highest to lowest is: divide error, software request, breakpoint, overflow, non-maskable, maskable, single-step.
- R3: The types are fixed as follows: divide error 0x00, single-step 0x01, non-maskable 0x02, breakpoint 0x03, overflow 0x04. A software request uses `sw_type_i` and a maskable request uses `intr_type_i`. The chosen type appears on `vec_type_o`.
- R4: A rising edge on `nmi_i` is remembered until it is serviced, whatever the value of `if_o`. A line held high produces only one service.
- R5: The maskable request is taken only if `intr_i` is high and `if_o` is 1 while the unit is idle. While `if_o` is 0 it starts no fetch.
- R6: The single-step trap is taken only if `step_i` is high and `tf_o` is 1.
- R7: The first read uses address type×4 and the second uses type×4+2, both zero-extended to 20 bits. `vec_ip_o` takes the first word read and `vec_cs_o` the second.
- R8: While `mem_rdy_i` is low during a read, `mem_rd_o` stays high and `mem_addr_o` does not change.
- R9: With W wait cycles per read, `done_o` is high for exactly one cycle, in the cycle that begins 2W+3 clock edges after the request is first present. The results stay held afterwards.
- R10: The edge that accepts a request clears `if_o` and `tf_o`, even when a flag write happens in the same cycle.
- R11: Internal and maskable requests present while `busy_o` is high are ignored and do not cause a later fetch.
- R12: When `flags_we_i` is high and no request is accepted, `if_o` and `tf_o` load `if_d_i` and `tf_d_i` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request line, serviced on its rising edge |
| intr_i | input | 1 | Maskable level-sensitive request |
| intr_type_i | input | 8 | Type supplied with the maskable request |
| div_err_i | input | 1 | Divide error request |
| sw_req_i | input | 1 | Software interrupt request |
| sw_type_i | input | 8 | Type of the software interrupt |
| bkpt_i | input | 1 | Breakpoint request |
| ovf_i | input | 1 | Overflow request |
| step_i | input | 1 | Instruction boundary for the single-step trap |
| flags_we_i | input | 1 | Flag write strobe |
| if_d_i | input | 1 | Interrupt-enable value to write |
| tf_d_i | input | 1 | Single-step value to write |
| mem_rdata_i | input | 16 | Read data from memory |
| mem_rdy_i | input | 1 | Read complete |
| mem_rd_o | output | 1 | Read request |
| mem_addr_o | output | 20 | Read address |
| if_o | output | 1 | Interrupt-enable flag |
| tf_o | output | 1 | Single-step flag |
| busy_o | output | 1 | A fetch is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| vec_ip_o | output | 16 | Fetched instruction offset |
| vec_cs_o | output | 16 | Fetched code segment |
| vec_type_o | output | 8 | Type being serviced |

## Verification
The request is accepted on the first clock edge after it is presented. Each read then takes W+1 cycles, so the completion pulse is due on the 2W+3rd falling edge after the inputs are applied. The flags read as cleared one edge after acceptance. The bench drives inputs on falling edges, counts falling edges until `done_o`, and compares that count with 2W+3. Read addresses are recorded only in cycles where the read and ready signals are both high. To show that an ignored request or a masked line had no effect, the bench watches `busy_o` over several falling edges after the stimulus.

// File: rtl/ivec_pkg.sv
`timescale 1ns/1ps
package ivec_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD_OFS,
      ST_RD_SEG,
      ST_DONE
   } fetch_st_t;

   localparam logic [7:0] TY_DIV  = 8'h00;
   localparam logic [7:0] TY_STEP = 8'h01;
   localparam logic [7:0] TY_NMI  = 8'h02;
   localparam logic [7:0] TY_BKPT = 8'h03;
   localparam logic [7:0] TY_OVF  = 8'h04;

endpackage

// File: rtl/ivec_nmi.sv
`timescale 1ns/1ps
module ivec_nmi #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_i,
   input  logic take_i,
   output logic req_o
);

   generate
      if (EDGE_MODE) begin : g_edge
         logic nmi_q;
         logic pend_q;
         logic rise;

         assign rise  = nmi_i & ~nmi_q;
         assign req_o = pend_q | rise;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               nmi_q  <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               nmi_q <= nmi_i;
               if (take_i)
                  pend_q <= 1'b0;
               else if (rise)
                  pend_q <= 1'b1;
            end
         end
      end else begin : g_level
         logic unused_lvl;
         assign unused_lvl = clk ^ rst_n ^ take_i;
         assign req_o      = nmi_i;
      end
   endgenerate

endmodule

// File: rtl/ivec_arb.sv
`timescale 1ns/1ps
module ivec_arb
   import ivec_pkg::*;
#(
   parameter int TYPE_W = 8
) (
   input  logic              div_i,
   input  logic              sw_i,
   input  logic [TYPE_W-1:0] sw_type_i,
   input  logic              bkpt_i,
   input  logic              ovf_i,
   input  logic              nmi_i,
   input  logic              intr_i,
   input  logic [TYPE_W-1:0] intr_type_i,
   input  logic              step_i,
   input  logic              if_i,
   input  logic              tf_i,
   output logic              win_o,
   output logic              win_nmi_o,
   output logic [TYPE_W-1:0] win_type_o
);

   logic intr_ok;
   logic step_ok;

   assign intr_ok = intr_i & if_i;
   assign step_ok = step_i & tf_i;

   always_comb begin
      win_o      = 1'b1;
      win_nmi_o  = 1'b0;
      win_type_o = '0;
      if (div_i)
         win_type_o = TYPE_W'(TY_DIV);
      else if (sw_i)
         win_type_o = sw_type_i;
      else if (bkpt_i)
         win_type_o = TYPE_W'(TY_BKPT);
      else if (ovf_i)
         win_type_o = TYPE_W'(TY_OVF);
      else if (nmi_i) begin
         win_type_o = TYPE_W'(TY_NMI);
         win_nmi_o  = 1'b1;
      end else if (intr_ok)
         win_type_o = intr_type_i;
      else if (step_ok)
         win_type_o = TYPE_W'(TY_STEP);
      else
         win_o = 1'b0;
   end

endmodule

// File: rtl/ivec_seq.sv
`timescale 1ns/1ps
module ivec_seq
   import ivec_pkg::*;
#(
   parameter int TYPE_W = 8,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_i,
   input  logic [TYPE_W-1:0] win_type_i,
   input  logic              flags_we_i,
   input  logic              if_d_i,
   input  logic              tf_d_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_rdy_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              if_o,
   output logic              tf_o,
   output logic              take_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] vec_ip_o,
   output logic [DATA_W-1:0] vec_cs_o,
   output logic [TYPE_W-1:0] vec_type_o
);

   localparam int SLOT_SH = 2;

   fetch_st_t         st_q;
   logic [TYPE_W-1:0] type_q;
   logic [DATA_W-1:0] ip_q;
   logic [DATA_W-1:0] cs_q;
   logic              if_q;
   logic              tf_q;
   logic [ADDR_W-1:0] base;

   assign take_o   = (st_q == ST_IDLE) && win_i;
   assign mem_rd_o = (st_q == ST_RD_OFS) || (st_q == ST_RD_SEG);
   assign busy_o   = (st_q != ST_IDLE);
   assign done_o   = (st_q == ST_DONE);

   assign base       = ADDR_W'({type_q, {SLOT_SH{1'b0}}});
   assign mem_addr_o = (st_q == ST_RD_SEG) ? (base | ADDR_W'(2)) : base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         type_q <= '0;
         ip_q   <= '0;
         cs_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (win_i) begin
                  type_q <= win_type_i;
                  st_q   <= ST_RD_OFS;
               end
            end
            ST_RD_OFS: begin
               if (mem_rdy_i) begin
                  ip_q <= mem_rdata_i;
                  st_q <= ST_RD_SEG;
               end
            end
            ST_RD_SEG: begin
               if (mem_rdy_i) begin
                  cs_q <= mem_rdata_i;
                  st_q <= ST_DONE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_q <= 1'b0;
         tf_q <= 1'b0;
      end else if (take_o) begin
         if_q <= 1'b0;
         tf_q <= 1'b0;
      end else if (flags_we_i) begin
         if_q <= if_d_i;
         tf_q <= tf_d_i;
      end
   end

   assign if_o       = if_q;
   assign tf_o       = tf_q;
   assign vec_ip_o   = ip_q;
   assign vec_cs_o   = cs_q;
   assign vec_type_o = type_q;

endmodule

// File: rtl/ivec_fetch.sv
`timescale 1ns/1ps
module ivec_fetch #(
   parameter int TYPE_W   = 8,
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 16,
   parameter bit NMI_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_i,
   input  logic              intr_i,
   input  logic [TYPE_W-1:0] intr_type_i,
   input  logic              div_err_i,
   input  logic              sw_req_i,
   input  logic [TYPE_W-1:0] sw_type_i,
   input  logic              bkpt_i,
   input  logic              ovf_i,
   input  logic              step_i,
   input  logic              flags_we_i,
   input  logic              if_d_i,
   input  logic              tf_d_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_rdy_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              if_o,
   output logic              tf_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] vec_ip_o,
   output logic [DATA_W-1:0] vec_cs_o,
   output logic [TYPE_W-1:0] vec_type_o
);

   generate
      if (TYPE_W < 3) begin : g_bad_type
         $error("TYPE_W must hold the fixed types");
      end
      if (ADDR_W < TYPE_W + 2) begin : g_bad_addr
         $error("ADDR_W too narrow for the vector table");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic              nmi_req;
   logic              win;
   logic              win_nmi;
   logic [TYPE_W-1:0] win_type;
   logic              take;

   ivec_nmi #(.EDGE_MODE(NMI_EDGE)) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .nmi_i  (nmi_i),
      .take_i (take & win_nmi),
      .req_o  (nmi_req)
   );

   ivec_arb #(.TYPE_W(TYPE_W)) u_arb (
      .div_i       (div_err_i),
      .sw_i        (sw_req_i),
      .sw_type_i   (sw_type_i),
      .bkpt_i      (bkpt_i),
      .ovf_i       (ovf_i),
      .nmi_i       (nmi_req),
      .intr_i      (intr_i),
      .intr_type_i (intr_type_i),
      .step_i      (step_i),
      .if_i        (if_o),
      .tf_i        (tf_o),
      .win_o       (win),
      .win_nmi_o   (win_nmi),
      .win_type_o  (win_type)
   );

   ivec_seq #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_i       (win),
      .win_type_i  (win_type),
      .flags_we_i  (flags_we_i),
      .if_d_i      (if_d_i),
      .tf_d_i      (tf_d_i),
      .mem_rdata_i (mem_rdata_i),
      .mem_rdy_i   (mem_rdy_i),
      .mem_rd_o    (mem_rd_o),
      .mem_addr_o  (mem_addr_o),
      .if_o        (if_o),
      .tf_o        (tf_o),
      .take_o      (take),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .vec_ip_o    (vec_ip_o),
      .vec_cs_o    (vec_cs_o),
      .vec_type_o  (vec_type_o)
   );

endmodule

// File: rtl/ivec_fetch_chk.sv
`timescale 1ns/1ps
module ivec_fetch_chk #(
   parameter int TYPE_W = 8,
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_o,
   input logic              mem_rdy_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              if_o,
   input logic              tf_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [TYPE_W-1:0] vec_type_o
);

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && !mem_rdy_i) |=> (mem_rd_o && $stable(mem_addr_o)));

   // R7
   seg_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && mem_rdy_i && !mem_addr_o[1]) |=>
      (mem_rd_o && mem_addr_o == ADDR_W'($past(mem_addr_o) + ADDR_W'(2))));

   // R7
   table_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> ((mem_addr_o >> (TYPE_W + 2)) == '0 && !mem_addr_o[0]));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   done_after_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(mem_rd_o && mem_rdy_i && mem_addr_o[1]));

   // R10
   accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (!if_o && !tf_o));

   // R11
   type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(vec_type_o));

endmodule

bind ivec_fetch ivec_fetch_chk #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_rd_o   (mem_rd_o),
   .mem_rdy_i  (mem_rdy_i),
   .mem_addr_o (mem_addr_o),
   .if_o       (if_o),
   .tf_o       (tf_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .vec_type_o (vec_type_o)
);

// File: tb/test_ivec_fetch.sv
`timescale 1ns/1ps
module test_ivec_fetch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi = 1'b0, intr = 1'b0, div_err = 1'b0, sw_req = 1'b0;
   logic        bkpt = 1'b0, ovf = 1'b0, step = 1'b0;
   logic [7:0]  intr_type = '0, sw_type = '0;
   logic        flags_we = 1'b0, if_d = 1'b0, tf_d = 1'b0;
   logic [15:0] mem_rdata;
   logic        mem_rdy;
   logic        mem_rd, if_o, tf_o, busy, done;
   logic [19:0] mem_addr;
   logic [15:0] vec_ip, vec_cs;
   logic [7:0]  vec_type;

   int total = 0;
   int bad = 0;
   logic [1:0] wait_n = 2'd0;
   logic [1:0] wcnt;

   always #5 clk = ~clk;

   ivec_fetch i_ivec_fetch (
      .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .intr_i(intr), .intr_type_i(intr_type),
      .div_err_i(div_err), .sw_req_i(sw_req), .sw_type_i(sw_type), .bkpt_i(bkpt),
      .ovf_i(ovf), .step_i(step), .flags_we_i(flags_we), .if_d_i(if_d), .tf_d_i(tf_d),
      .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy), .mem_rd_o(mem_rd),
      .mem_addr_o(mem_addr), .if_o(if_o), .tf_o(tf_o), .busy_o(busy), .done_o(done),
      .vec_ip_o(vec_ip), .vec_cs_o(vec_cs), .vec_type_o(vec_type)
   );

   function automatic logic [15:0] mword(input logic [19:0] a);
      return (a[15:0] * 16'd7) ^ 16'hC35A;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n || !mem_rd || mem_rdy) wcnt <= 2'd0;
      else wcnt <= wcnt + 2'd1;
   end
   assign mem_rdy   = mem_rd && (wcnt == wait_n);
   assign mem_rdata = mword(mem_addr);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drop_reqs();
      nmi = 0; intr = 0; div_err = 0; sw_req = 0; bkpt = 0; ovf = 0; step = 0;
   endtask

   task automatic write_flags(input logic fi, input logic ft);
      @(negedge clk);
      flags_we = 1; if_d = fi; tf_d = ft;
      @(negedge clk);
      flags_we = 0;
   endtask

   // waits on falling edges for done; returns the edge count and both read addresses
   task automatic wait_done(input bit drop, output int k, output logic [19:0] a0,
                            output logic [19:0] a1);
      int n;
      n = 0; a0 = '1; a1 = '1; k = 0;
      for (int i = 1; i <= 60; i++) begin
         @(negedge clk);
         if (i == 1 && drop) drop_reqs();
         if (mem_rd && mem_rdy) begin
            if (n == 0) a0 = mem_addr; else a1 = mem_addr;
            n++;
         end
         if (done) begin k = i; break; end
      end
   endtask

   task automatic idle_for(input int n, input string tag);
      int seen;
      seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (busy) seen++;
      end
      chk(tag, seen, 0);
   endtask

   // fields: req{div,sw,bkpt,ovf,nmi,intr,step}, sw type, intr type, if, tf, wait, expected type
   localparam int NV = 13;
   localparam logic [34:0] TBL [NV] = '{
      {7'b0000010, 8'h00, 8'h21, 1'b1, 1'b0, 2'd0, 8'h21},
      {7'b0000010, 8'h00, 8'hFF, 1'b1, 1'b0, 2'd1, 8'hFF},
      {7'b1000010, 8'h00, 8'h33, 1'b1, 1'b0, 2'd0, 8'h00},
      {7'b0100010, 8'h80, 8'h44, 1'b1, 1'b0, 2'd2, 8'h80},
      {7'b0011000, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 8'h03},
      {7'b0001000, 8'h00, 8'h00, 1'b0, 1'b0, 2'd3, 8'h04},
      {7'b0000110, 8'h00, 8'h55, 1'b1, 1'b0, 2'd1, 8'h02},
      {7'b0000100, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 8'h02},
      {7'b0000011, 8'h00, 8'h66, 1'b0, 1'b1, 2'd0, 8'h01},
      {7'b0000011, 8'h00, 8'h40, 1'b1, 1'b1, 2'd0, 8'h40},
      {7'b0110000, 8'h05, 8'h00, 1'b0, 1'b0, 2'd1, 8'h05},
      {7'b0001001, 8'h00, 8'h00, 1'b0, 1'b1, 2'd0, 8'h04},
      {7'b0100000, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00}
   };

   initial begin
      #200000;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int k;
      logic [19:0] a0, a1, t4;
      logic [34:0] v;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 rd", mem_rd, 0);
      chk("R1 flags", {if_o, tf_o}, 0);
      chk("R1 results", {vec_ip, vec_cs, vec_type}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int j = 0; j < NV; j++) begin
         v = TBL[j];
         wait_n = v[9:8];
         write_flags(v[11], v[10]);
         {div_err, sw_req, bkpt, ovf, nmi, intr, step} = v[34:28];
         sw_type = v[27:20]; intr_type = v[19:12];
         wait_done(1'b1, k, a0, a1);
         t4 = {10'd0, v[7:0], 2'b00};
         chk($sformatf("R9 latency v%0d", j), k, 2 * v[9:8] + 3);
         chk($sformatf("R2 R3 type v%0d", j), vec_type, v[7:0]);
         chk($sformatf("R7 addr0 v%0d", j), a0, t4);
         chk($sformatf("R7 addr1 v%0d", j), a1, t4 + 20'd2);
         chk($sformatf("R7 ip v%0d", j), vec_ip, mword(t4));
         chk($sformatf("R7 cs v%0d", j), vec_cs, mword(t4 + 20'd2));
         chk($sformatf("R10 flags v%0d", j), {if_o, tf_o}, 0);
         idle_for(3, $sformatf("R9 no refetch v%0d", j));
      end

      // R12 flag write and read back
      write_flags(1'b1, 1'b1);
      chk("R12 set", {if_o, tf_o}, 2'b11);
      write_flags(1'b0, 1'b0);
      chk("R12 clear", {if_o, tf_o}, 2'b00);

      // R5 masked level request starts nothing, then taken once enabled
      wait_n = 2'd0;
      intr = 1; intr_type = 8'h12;
      idle_for(8, "R5 masked intr");
      write_flags(1'b1, 1'b0);
      wait_done(1'b0, k, a0, a1);
      chk("R5 intr type", vec_type, 8'h12);
      idle_for(6, "R10 held intr blocked");
      intr = 0;

      // R6 step without the trap flag
      step = 1;
      idle_for(6, "R6 step masked");
      step = 0;

      // R4 nmi behind divide error is still serviced
      @(negedge clk);
      div_err = 1; nmi = 1;
      wait_done(1'b1, k, a0, a1);
      chk("R2 div first", vec_type, 8'h00);
      wait_done(1'b0, k, a0, a1);
      chk("R4 nmi later", vec_type, 8'h02);
      chk("R4 nmi latency", k, 4);
      idle_for(4, "R4 single nmi");

      // R4 nmi held high gives one service
      nmi = 1;
      wait_done(1'b0, k, a0, a1);
      chk("R4 held nmi", vec_type, 8'h02);
      idle_for(8, "R4 held nmi once");
      nmi = 0;

      // R11 requests during a fetch are dropped
      wait_n = 2'd3;
      write_flags(1'b1, 1'b0);
      intr = 1; intr_type = 8'h77;
      k = 0;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (i == 1) intr = 0;
         if (i == 2) begin div_err = 1; sw_req = 1; sw_type = 8'h99; ovf = 1; end
         if (i == 6) drop_reqs();
         if (done) begin k = i; break; end
      end
      chk("R9 latency w3", k, 9);
      chk("R11 type", vec_type, 8'h77);
      idle_for(5, "R11 ignored busy reqs");

      // R10 accept overrides a same-cycle flag write
      wait_n = 2'd0;
      @(negedge clk);
      ovf = 1; flags_we = 1; if_d = 1; tf_d = 1;
      @(negedge clk);
      ovf = 0; flags_we = 0;
      chk("R10 write overridden", {if_o, tf_o}, 2'b00);
      wait_done(1'b0, k, a0, a1);
      chk("R3 ovf type", vec_type, 8'h04);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule